// File: doc/BRIEF.md
# Translation Cache with Clean-Page Store Trap

This block is a small fully associative cache of page translations for 4 KB pages. Each cycle it can take one lookup: a virtual address plus a flag saying whether the access is a store. One cycle later it reports one of three outcomes. The translation can be missing, which raises a miss exception. The translation can hit, which returns the physical address. Or a store can hit a page whose writable-dirty flag is clear, which raises a separate clean-store exception. The physical address is the cached frame number joined to the untranslated low 12 address bits.

Software fills the cache through a refill port. A clean page is loaded with its writable-dirty flag clear, and a dirty page is loaded with the flag set. When a store traps on a clean page, the handler records that the page is dirty and refills the same virtual page with the flag set. The retried store then completes. A refill whose page number is already cached overwrites that slot instead of the slot named by the refill index, so one page never hits in two places. A separate shootdown port removes the entry for one virtual page number.

Top module: `trans_cache`

## Requirements
- R1: A lookup whose virtual page number (address bits 31:12) matches no valid entry gives rsp_valid=1, rsp_miss=1, rsp_hit=0, rsp_wclean=0 and rsp_paddr=0 one cycle later.
- R2: A lookup that hits gives rsp_hit=1, rsp_miss=0 and rsp_paddr equal to the entry's frame number in bits 31:12 and the request's address bits 11:0 in bits 11:0.
- R3: A store (req_store=1) that hits an entry whose writable-dirty flag is 0 gives rsp_wclean=1 with rsp_hit=1, so the store must not complete.
- R4: A load (req_store=0) that hits an entry whose writable-dirty flag is 0 completes with rsp_wclean=0.
- R5: A store that hits an entry whose writable-dirty flag is 1 completes with rsp_wclean=0.
- R6: A refill (fill_en=1) with no matching valid entry writes slot fill_idx with fill_vpn, fill_pfn and fill_mod, and the entry is valid. Lookups see it from the next cycle on. A lookup in the same cycle as the refill sees the old contents.
- R7: A refill whose fill_vpn matches a valid entry overwrites that entry and leaves slot fill_idx untouched, so at most one entry ever hits. Rewriting a trapped page with fill_mod=1 lets the retried store complete.
- R8: A shootdown (inv_en=1) invalidates the valid entry whose page number equals inv_vpn, and the other entries stay usable.
- R9: After reset every entry is invalid and rsp_valid is 0. During reset all response outputs are 0.
- R10: In a cycle after req_valid=0, rsp_valid, rsp_hit, rsp_miss and rsp_wclean are all 0 and rsp_paddr is 0.
- R11: When a refill and a shootdown occur in the same cycle, the slot written by the refill ends valid with the new contents, and the shootdown still removes any other entry matching inv_vpn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request this cycle |
| req_store | input | 1 | Lookup is a store (1) or a load (0) |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss exception |
| rsp_wclean | output | 1 | Store to a clean page exception |
| rsp_paddr | output | 32 | Translated physical address, 0 on miss |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | 3 | Slot to write when the page is not yet cached |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_pfn | input | 20 | Physical frame number to store |
| fill_mod | input | 1 | Writable-dirty flag to store |
| inv_en | input | 1 | Shoot down one page |
| inv_vpn | input | 20 | Virtual page number to remove |

## Verification
Every lookup result is due exactly one clock edge after the edge that samples the request. Refills and shootdowns change the stored state at that same edge, so they first affect a lookup issued in the following cycle. The bench drives each cycle's inputs at the falling edge and computes that cycle's expected response from its model state before it updates the model. It then waits past the next rising edge and compares every response output at the falling edge that follows. This keeps the comparison one edge behind the stimulus, as the design's registering requires.

// File: rtl/trans_cache_pkg.sv
package trans_cache_pkg;

   // Untranslated offset width for 4 KB pages.
   localparam int unsigned PAGE_OFF_W = 12;

   // Outcome of one lookup, decided before the response register.
   typedef enum logic [1:0] {
      LK_IDLE   = 2'd0,
      LK_MISS   = 2'd1,
      LK_HIT    = 2'd2,
      LK_WCLEAN = 2'd3
   } lk_kind_e;

   function automatic lk_kind_e classify(input logic valid, input logic any_hit,
                                         input logic store, input logic dirty);
      if (!valid)               return LK_IDLE;
      else if (!any_hit)        return LK_MISS;
      else if (store && !dirty) return LK_WCLEAN;
      else                      return LK_HIT;
   endfunction

endpackage

// File: rtl/trans_cache_entry.sv
module trans_cache_entry #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PFN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PFN_W-1:0] wr_pfn,
   input  logic             wr_mod,
   input  logic             inv_en,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [VPN_W-1:0] look_vpn,
   input  logic [VPN_W-1:0] fill_vpn,
   output logic             look_hit,
   output logic             fill_hit,
   output logic [PFN_W-1:0] e_pfn,
   output logic             e_mod
);

   logic             valid_q;
   logic [VPN_W-1:0] vpn_q;
   logic [PFN_W-1:0] pfn_q;
   logic             mod_q;
   logic             kill;

   assign kill = inv_en && valid_q && (vpn_q == inv_vpn) && !wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
      end else if (kill) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         vpn_q <= wr_vpn;
         pfn_q <= wr_pfn;
         mod_q <= wr_mod;
      end
   end

   assign look_hit = valid_q && (vpn_q == look_vpn);
   assign fill_hit = valid_q && (vpn_q == fill_vpn);
   assign e_pfn    = pfn_q;
   assign e_mod    = mod_q;

   // R6: a write leaves the slot valid holding the written page number
   p_fill_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q && (vpn_q == $past(wr_vpn)) && (pfn_q == $past(wr_pfn))));

   // R8: a shootdown of this slot's page without a write clears it
   p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && look_hit && (look_vpn == inv_vpn) && !wr_en) |=> !valid_q);

endmodule

// File: rtl/trans_cache_enc.sv
module trans_cache_enc #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  sel,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (N < 2) begin : g_bad_n
         $error("trans_cache_enc needs at least two inputs");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) idx = idx | IW'(i);
      end
   end

   assign any = |sel;

endmodule

// File: rtl/trans_cache_mux.sv
module trans_cache_mux #(
   parameter int unsigned N      = 8,
   parameter int unsigned W      = 20,
   parameter bit          AND_OR = 1'b1
) (
   input  logic [N-1:0]   sel,
   input  logic [N*W-1:0] data_flat,
   input  logic [N-1:0]   flag_vec,
   output logic           any,
   output logic [W-1:0]   data,
   output logic           flag
);

   generate
      if (AND_OR) begin : g_and_or
         // Shallow OR tree; relies on at most one select being set.
         always_comb begin
            data = '0;
            flag = 1'b0;
            for (int i = 0; i < N; i++) begin
               data = data | (data_flat[i*W +: W] & {W{sel[i]}});
               flag = flag | (flag_vec[i] & sel[i]);
            end
         end
      end else begin : g_priority
         // Lowest index wins; deeper but tolerant of multiple selects.
         always_comb begin
            data = '0;
            flag = 1'b0;
            for (int i = N - 1; i >= 0; i--) begin
               if (sel[i]) begin
                  data = data_flat[i*W +: W];
                  flag = flag_vec[i];
               end
            end
         end
      end
   endgenerate

   assign any = |sel;

endmodule

// File: rtl/trans_cache.sv
module trans_cache
   import trans_cache_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter bit          AND_OR  = 1'b1,
   localparam int unsigned OFF_W  = PAGE_OFF_W,
   localparam int unsigned VA_W   = VPN_W + OFF_W,
   localparam int unsigned PA_W   = PFN_W + OFF_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_store,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_wclean,
   output logic [PA_W-1:0]  rsp_paddr,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_mod,
   input  logic             inv_en,
   input  logic [VPN_W-1:0] inv_vpn
);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("trans_cache needs at least two entries");
      end
      if ((1 << IDX_W) != ENTRIES) begin : g_bad_pow2
         $error("trans_cache entry count must be a power of two");
      end
      if (VPN_W < 1 || PFN_W < 1) begin : g_bad_width
         $error("trans_cache page number widths must be positive");
      end
   endgenerate

   logic [VPN_W-1:0]       look_vpn;
   logic [ENTRIES-1:0]     look_hit;
   logic [ENTRIES-1:0]     fill_hit;
   logic [ENTRIES-1:0]     e_mod;
   logic [ENTRIES*PFN_W-1:0] e_pfn_flat;
   logic                   hit_any;
   logic [PFN_W-1:0]       hit_pfn;
   logic                   hit_mod;
   logic                   fill_any;
   logic [IDX_W-1:0]       fill_match_idx;
   logic [IDX_W-1:0]       fill_tgt;
   lk_kind_e               kind;

   assign look_vpn = req_vaddr[VA_W-1:OFF_W];

   // A refill of a cached page lands on its current slot.
   trans_cache_enc #(.N(ENTRIES)) u_fill_enc (
      .sel (fill_hit),
      .any (fill_any),
      .idx (fill_match_idx)
   );

   assign fill_tgt = fill_any ? fill_match_idx : fill_idx;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic slot_wr;
      assign slot_wr = fill_en && (fill_tgt == IDX_W'(g));
      trans_cache_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (slot_wr),
         .wr_vpn   (fill_vpn),
         .wr_pfn   (fill_pfn),
         .wr_mod   (fill_mod),
         .inv_en   (inv_en),
         .inv_vpn  (inv_vpn),
         .look_vpn (look_vpn),
         .fill_vpn (fill_vpn),
         .look_hit (look_hit[g]),
         .fill_hit (fill_hit[g]),
         .e_pfn    (e_pfn_flat[g*PFN_W +: PFN_W]),
         .e_mod    (e_mod[g])
      );
   end

   trans_cache_mux #(.N(ENTRIES), .W(PFN_W), .AND_OR(AND_OR)) u_hit_mux (
      .sel       (look_hit),
      .data_flat (e_pfn_flat),
      .flag_vec  (e_mod),
      .any       (hit_any),
      .data      (hit_pfn),
      .flag      (hit_mod)
   );

   assign kind = classify(req_valid, hit_any, req_store, hit_mod);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_wclean <= 1'b0;
         rsp_paddr  <= '0;
      end else begin
         rsp_valid  <= (kind != LK_IDLE);
         rsp_hit    <= (kind == LK_HIT) || (kind == LK_WCLEAN);
         rsp_miss   <= (kind == LK_MISS);
         rsp_wclean <= (kind == LK_WCLEAN);
         rsp_paddr  <= ((kind == LK_HIT) || (kind == LK_WCLEAN)) ?
                       {hit_pfn, req_vaddr[OFF_W-1:0]} : '0;
      end
   end

   // R7: never two slots answering the same page
   p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit));

   p_single_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_hit));

   // R1: miss and hit are exclusive and a miss returns no address
   p_miss_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (!rsp_hit && !rsp_wclean && (rsp_paddr == '0)));

   // R3: the clean-store trap only follows a store request that hit
   p_wclean_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wclean |-> (rsp_hit && $past(req_store) && $past(req_valid)));

   // R4: loads never trap
   p_load_no_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store) |=> !rsp_wclean);

   // R10: no request, quiet response
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_wclean));

   // R10: every request is answered on the next edge
   p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_valid && (rsp_hit != rsp_miss)));

endmodule

// File: tb/trans_cache_test.sv
`timescale 1ns/1ps
module trans_cache_test;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_wclean;
   logic [31:0] rsp_paddr;
   logic        fill_en = 1'b0, fill_mod = 1'b0, inv_en = 1'b0;
   logic [2:0]  fill_idx = '0;
   logic [19:0] fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Behavioural model state
   bit          m_v   [N];
   int unsigned m_vpn [N];
   int unsigned m_pfn [N];
   bit          m_mod [N];

   always #2 clk = ~clk;

   trans_cache uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_wclean(rsp_wclean), .rsp_paddr(rsp_paddr),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
      .fill_pfn(fill_pfn), .fill_mod(fill_mod),
      .inv_en(inv_en), .inv_vpn(inv_vpn)
   );

   task automatic compare(input string tag, input bit ev, input bit eh,
                          input bit em, input bit ew, input logic [31:0] ep);
      checks++;
      if (rsp_valid !== ev || rsp_hit !== eh || rsp_miss !== em ||
          rsp_wclean !== ew || rsp_paddr !== ep) begin
         fails++;
         $display("FAIL %s: got v=%b h=%b m=%b w=%b pa=%h, expected v=%b h=%b m=%b w=%b pa=%h",
                  tag, rsp_valid, rsp_hit, rsp_miss, rsp_wclean, rsp_paddr,
                  ev, eh, em, ew, ep);
      end
   endtask

   // One clock: expectation from the pre-edge model, then model update.
   task automatic cyc(input string tag);
      bit ev, eh, em, ew;
      logic [31:0] ep;
      int found, tgt;
      ev = req_valid; eh = 0; em = 0; ew = 0; ep = '0;
      if (req_valid) begin
         found = -1;
         for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == req_vaddr[31:12]) found = i;
         if (found < 0) em = 1;
         else begin
            eh = 1;
            ep = {m_pfn[found][19:0], req_vaddr[11:0]};
            ew = req_store && !m_mod[found];
         end
      end
      tgt = -1;
      if (fill_en) begin
         tgt = fill_idx;
         for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == fill_vpn) tgt = i;
      end
      if (inv_en)
         for (int i = 0; i < N; i++)
            if (i != tgt && m_v[i] && m_vpn[i] == inv_vpn) m_v[i] = 0;
      if (tgt >= 0) begin
         m_v[tgt] = 1; m_vpn[tgt] = fill_vpn; m_pfn[tgt] = fill_pfn;
         m_mod[tgt] = fill_mod;
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag, ev, eh, em, ew, ep);
   endtask

   task automatic quiet();
      req_valid = 0; req_store = 0; fill_en = 0; inv_en = 0;
   endtask

   task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                       input bit st, input string tag);
      quiet();
      req_valid = 1; req_store = st; req_vaddr = {vpn, off};
      cyc(tag);
   endtask

   task automatic fill(input int idx, input logic [19:0] vpn,
                       input logic [19:0] pfn, input bit md, input string tag);
      quiet();
      fill_en = 1; fill_idx = 3'(idx); fill_vpn = vpn; fill_pfn = pfn; fill_mod = md;
      cyc(tag);
   endtask

   task automatic shoot(input logic [19:0] vpn, input string tag);
      quiet();
      inv_en = 1; inv_vpn = vpn;
      cyc(tag);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got no completion, expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      // R9: outputs quiet while reset is held, even with a request driven
      req_valid = 1; req_vaddr = 32'h0000_1000;
      repeat (3) @(negedge clk);
      compare("R9 in reset", 0, 0, 0, 0, '0);
      req_valid = 0;
      rst_n = 1;
      @(negedge clk);
      look(20'h00000, 12'h000, 0, "R9 empty after reset");
      look(20'h00001, 12'h234, 1, "R1 miss store");
      look(20'hFFFFF, 12'hFFF, 0, "R1 miss top page");
      quiet(); cyc("R10 idle");

      // R6: fill slot 0 clean; same-cycle lookup still misses
      quiet();
      fill_en = 1; fill_idx = 0; fill_vpn = 20'h12345; fill_pfn = 20'hABCDE; fill_mod = 0;
      req_valid = 1; req_vaddr = 32'h1234_5010;
      cyc("R6 lookup during fill sees old");
      look(20'h12345, 12'h678, 0, "R4 load to clean page");
      look(20'h12345, 12'h001, 1, "R3 store to clean page traps");

      // R7: slot 5 holds another page, refill of cached page must not touch it
      fill(5, 20'h00BEE, 20'h00F00, 0, "R6 fill slot 5");
      fill(5, 20'h12345, 20'hABCDE, 1, "R7 refill cached page as writable");
      look(20'h12345, 12'h001, 1, "R7 retried store completes");
      look(20'h00BEE, 12'hFED, 0, "R7 slot 5 untouched");
      look(20'h12345, 12'h800, 1, "R5 store to writable page");

      // R2: several pages, varied offsets
      for (int i = 1; i < N; i++) if (i != 5)
         fill(i, 20'(32'h40000 + i * 3), 20'(32'h77000 + i * 17), i[0], "R6 fill sweep");
      for (int i = 1; i < N; i++) if (i != 5)
         look(20'(32'h40000 + i * 3), 12'(i * 291), i[1], "R2 hit sweep");

      // R8: shootdown removes one page, others stay
      shoot(20'h12345, "R8 shootdown");
      look(20'h12345, 12'h001, 0, "R8 shot page misses");
      look(20'h00BEE, 12'h010, 0, "R8 other page kept");
      shoot(20'h55555, "R8 shootdown of absent page");
      look(20'h00BEE, 12'h020, 1, "R8 absent shootdown harmless");

      // R11: fill and shootdown together
      quiet();
      fill_en = 1; fill_idx = 0; fill_vpn = 20'h0C0DE; fill_pfn = 20'h11111; fill_mod = 1;
      inv_en = 1; inv_vpn = 20'h0C0DE;
      cyc("R11 fill and shoot same page");
      look(20'h0C0DE, 12'h333, 1, "R11 filled page survives");
      quiet();
      fill_en = 1; fill_idx = 0; fill_vpn = 20'h0C0DE; fill_pfn = 20'h22222; fill_mod = 0;
      inv_en = 1; inv_vpn = 20'h00BEE;
      cyc("R11 fill and shoot other page");
      look(20'h00BEE, 12'h000, 0, "R11 other page removed");
      look(20'h0C0DE, 12'h444, 1, "R11 rewritten page clean");

      // Mixed traffic over a small page pool
      for (int k = 0; k < 400; k++) begin
         quiet();
         req_valid = ($urandom_range(0, 3) != 0);
         req_store = $urandom_range(0, 1);
         req_vaddr = {20'($urandom_range(0, 11)), 12'($urandom)};
         fill_en   = ($urandom_range(0, 3) == 0);
         fill_idx  = 3'($urandom);
         fill_vpn  = 20'($urandom_range(0, 11));
         fill_pfn  = 20'($urandom);
         fill_mod  = $urandom_range(0, 1);
         inv_en    = ($urandom_range(0, 5) == 0);
         inv_vpn   = 20'($urandom_range(0, 11));
         cyc("R2 R3 R7 mixed traffic");
      end
      quiet(); cyc("R10 final idle");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule